// File: doc/BRIEF.md
# Sequence Timing and Call Controller

This block carries the blocking time operations and the nested call mechanism of an instruction sequencer. It keeps its own notion of on-board time. A prescaler turns the core clock into 50 ms ticks, and a second divider turns ticks into whole seconds. The sequencer hands over one time or call operation at a time. The block either completes it on the next cycle or holds `busy` until the condition is met. It then pulses `adv` to tell the sequencer to move to the next instruction.

Four operations suspend, or may suspend:
- A plain tick wait.
- A cadence delay measured from the previous delay point.
- A set-reference operation that captures the current second.
- A timed hold relative to that reference.

Calls push the return address together with the current delay point onto a ten-entry stack, and returns restore both. Pushing onto a full stack or popping an empty one reports an error and leaves everything as it was.

All elapsed-time comparisons use modular differences of the free-running counters, so they stay correct across a counter wrap.

Top module: `seqtc_ctl`

## Requirements
- R1: After reset `tick_now` is 0. It then increases by one, modulo 2^TICK_W, once every TICK_CYCLES clock cycles.
- R2: After reset `sec_now` is 0. It increases by one, modulo 2^SEC_W, on every TICKS_PER_SEC-th tick.
- R3: `cmd_op` is decoded as 1 = wait, 2 = delay, 3 = set reference, 4 = timed hold, 5 = call, 6 = return. Codes 0 and 7 do nothing. A command is taken only while `busy` is low; a command offered while `busy` is high has no effect.
- R4: A wait with argument N (low TICK_W bits) treats N of 0 or 1 as 1. It raises `busy` and ends with a one-cycle `adv` in the cycle after the tick count has moved N past its value at acceptance.
- R5: A delay with argument N that is not yet due holds `busy` until `tick_now` minus the delay point reaches N. It then pulses `adv` and makes the current tick the new delay point.
- R6: A delay whose N ticks since the delay point have already elapsed (including N = 0) does not raise `busy`. It pulses `adv` in the next cycle and moves the delay point to the current tick. The delay point is 0 after reset.
- R7: Set reference captures `sec_now` as the reference second and pulses `adv` in the next cycle.
- R8: A timed hold with argument N holds until `sec_now` minus the reference second is at least N. If that is already true on acceptance, it pulses `adv` in the next cycle without raising `busy`.
- R9: A call pushes `cmd_ret_addr` and the current delay point onto a STACK_DEPTH-entry (10) stack and pulses `adv`.
- R10: A return pops the newest entry in last-in first-out order. It pulses `ret_valid` and `adv` with `ret_addr` set to the saved address, and restores the saved delay point.
- R11: A call with the stack full pulses `stk_err` without `adv` and leaves the stack contents unchanged.
- R12: A return with the stack empty pulses `stk_err` without `adv` or `ret_valid` and leaves the delay point unchanged.
- R13: Tick and second comparisons are made on modular differences and stay correct when `tick_now` or `sec_now` wraps during a delay or timed hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 32 | Tick or second count argument |
| cmd_ret_addr | input | ADDR_W | Return address for a call |
| busy | output | 1 | A suspending command is in progress |
| adv | output | 1 | One-cycle pulse: sequencer may advance |
| ret_valid | output | 1 | One-cycle pulse: a return popped an entry |
| ret_addr | output | ADDR_W | Address restored by the last return |
| stk_err | output | 1 | One-cycle pulse: stack overflow or underflow |
| tick_now | output | TICK_W | Current tick count |
| sec_now | output | SEC_W | Current second count |

## Verification
Two pairs of events can share a cycle. A tick edge can land on the same clock edge at which a wait or delay is accepted or checked. A wrap of the tick or second counter can fall inside a pending delay or timed hold. The bench issues commands back to back on arbitrary phases of the prescaler, runs a delay and a timed hold across both counter wraps, and offers commands while a hold is pending. A behavioural model holds time as plain integers and the stack as queues. On every cycle it predicts the counters, `busy`, `adv`, `ret_valid`, `ret_addr` and `stk_err`, and the bench compares each of them.

// File: rtl/seqtc_pkg.sv
package seqtc_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WAIT  = 3'd1,
    OP_DELAY = 3'd2,
    OP_SRT   = 3'd3,
    OP_TIM   = 3'd4,
    OP_CALL  = 3'd5,
    OP_RET   = 3'd6,
    OP_RSVD  = 3'd7
  } seq_op_e;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_WAIT  = 2'd1,
    M_DELAY = 2'd2,
    M_TIM   = 2'd3
  } hold_mode_e;

  // Mask keeping the low w bits of a 32-bit value.
  function automatic logic [31:0] width_mask(input int unsigned w);
    if (w >= 32) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction

  // True when (now - mark) modulo 2^w is at least span modulo 2^w.
  function automatic logic span_reached(input logic [31:0] now,
                                        input logic [31:0] mark,
                                        input logic [31:0] span,
                                        input int unsigned w);
    logic [31:0] m;
    m = width_mask(w);
    return (((now - mark) & m) >= (span & m));
  endfunction

  // Wait length: 0 and 1 both mean one tick.
  function automatic logic [31:0] wait_len(input logic [31:0] n,
                                           input int unsigned w);
    logic [31:0] v;
    v = n & width_mask(w);
    return (v <= 32'd1) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/seqtc_timebase.sv
module seqtc_timebase #(
  parameter int unsigned TICK_CYCLES   = 10_000_000,
  parameter int unsigned TICKS_PER_SEC = 20,
  parameter int unsigned TICK_W        = 16,
  parameter int unsigned SEC_W         = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick_o,
  output logic [SEC_W-1:0]  sec_o
);
  localparam int unsigned PW = $clog2(TICK_CYCLES);
  localparam int unsigned SW = $clog2(TICKS_PER_SEC);

  logic [PW-1:0] pre_q;
  logic [SW-1:0] sub_q;
  logic          tick_evt;
  logic          sec_evt;

  assign tick_evt = (pre_q == PW'(TICK_CYCLES - 1));
  assign sec_evt  = tick_evt && (sub_q == SW'(TICKS_PER_SEC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sub_q  <= '0;
      tick_o <= '0;
      sec_o  <= '0;
    end else begin
      pre_q <= tick_evt ? '0 : pre_q + PW'(1);
      if (tick_evt) begin
        tick_o <= tick_o + TICK_W'(1);
        sub_q  <= sec_evt ? '0 : sub_q + SW'(1);
      end
      if (sec_evt) sec_o <= sec_o + SEC_W'(1);
    end
  end

  // R1: the tick count only ever steps by one
  a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o != $past(tick_o)) |-> (tick_o == $past(tick_o) + TICK_W'(1)));

  // R2: the second count moves only together with a tick
  a_r2_sec_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o != $past(sec_o)) |-> ((tick_o != $past(tick_o)) &&
                                 (sec_o == $past(sec_o) + SEC_W'(1))));
endmodule

// File: rtl/seqtc_lifo.sv
module seqtc_lifo #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top_idx;
  logic          do_push;
  logic          do_pop;
  logic [W-1:0]  slot_q [DEPTH];

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty && !push;
  assign top_idx = cnt_q - CW'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] data_q;
    always_ff @(posedge clk) begin
      if (do_push && cnt_q == CW'(g)) data_q <= din;
    end
    assign slot_q[g] = data_q;
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!empty && top_idx == CW'(i)) top = slot_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (do_push) cnt_q <= cnt_q + CW'(1);
    else if (do_pop)  cnt_q <= cnt_q - CW'(1);
  end

  // R11: a push onto a full stack changes nothing
  a_r11_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (full && $stable(top)));

  // R12: a pop from an empty stack leaves it empty
  a_r12_empty_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
endmodule

// File: rtl/seqtc_ctl.sv
module seqtc_ctl
  import seqtc_pkg::*;
#(
  parameter int unsigned TICK_CYCLES   = 10_000_000,
  parameter int unsigned TICKS_PER_SEC = 20,
  parameter int unsigned TICK_W        = 16,
  parameter int unsigned SEC_W         = 32,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned STACK_DEPTH   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [31:0]       cmd_arg,
  input  logic [ADDR_W-1:0] cmd_ret_addr,
  output logic              busy,
  output logic              adv,
  output logic              ret_valid,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              stk_err,
  output logic [TICK_W-1:0] tick_now,
  output logic [SEC_W-1:0]  sec_now
);
  localparam int unsigned ENT_W = ADDR_W + TICK_W;

  hold_mode_e        mode_q;
  logic [TICK_W-1:0] start_q;
  logic [TICK_W-1:0] dref_q;
  logic [SEC_W-1:0]  rsec_q;
  logic [31:0]       span_q;
  logic              adv_q, rv_q, err_q;
  logic [ADDR_W-1:0] raddr_q;

  seq_op_e           op;
  logic              accept;
  logic              late_evt, tim_now_evt;
  logic              wait_met, delay_met, tim_met, hold_done;
  logic              push_req, pop_req, ovf_evt, unf_evt;
  logic [ENT_W-1:0]  stk_top;
  logic              stk_full, stk_empty;

  seqtc_timebase #(
    .TICK_CYCLES  (TICK_CYCLES),
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .TICK_W       (TICK_W),
    .SEC_W        (SEC_W)
  ) u_timebase (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick_now),
    .sec_o (sec_now)
  );

  assign op     = seq_op_e'(cmd_op);
  assign accept = cmd_valid && (mode_q == M_IDLE);

  // Named events for the checks below
  assign late_evt    = accept && (op == OP_DELAY) &&
                       span_reached(32'(tick_now), 32'(dref_q), cmd_arg, TICK_W);
  assign tim_now_evt = accept && (op == OP_TIM) &&
                       span_reached(32'(sec_now), 32'(rsec_q), cmd_arg, SEC_W);
  assign wait_met    = span_reached(32'(tick_now), 32'(start_q), span_q, TICK_W);
  assign delay_met   = span_reached(32'(tick_now), 32'(dref_q), span_q, TICK_W);
  assign tim_met     = span_reached(32'(sec_now), 32'(rsec_q), span_q, SEC_W);
  assign hold_done   = ((mode_q == M_WAIT)  && wait_met)  ||
                       ((mode_q == M_DELAY) && delay_met) ||
                       ((mode_q == M_TIM)   && tim_met);

  assign push_req = accept && (op == OP_CALL);
  assign pop_req  = accept && (op == OP_RET);
  assign ovf_evt  = push_req && stk_full;
  assign unf_evt  = pop_req && stk_empty;

  seqtc_lifo #(
    .DEPTH(STACK_DEPTH),
    .W    (ENT_W)
  ) u_lifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push_req),
    .pop  (pop_req),
    .din  ({cmd_ret_addr, dref_q}),
    .top  (stk_top),
    .full (stk_full),
    .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      start_q <= '0;
      dref_q  <= '0;
      rsec_q  <= '0;
      span_q  <= '0;
      adv_q   <= 1'b0;
      rv_q    <= 1'b0;
      err_q   <= 1'b0;
      raddr_q <= '0;
    end else begin
      adv_q <= 1'b0;
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      if (accept) begin
        case (op)
          OP_WAIT: begin
            start_q <= tick_now;
            span_q  <= wait_len(cmd_arg, TICK_W);
            mode_q  <= M_WAIT;
          end
          OP_DELAY: begin
            if (late_evt) begin
              adv_q  <= 1'b1;
              dref_q <= tick_now;
            end else begin
              span_q <= cmd_arg;
              mode_q <= M_DELAY;
            end
          end
          OP_SRT: begin
            rsec_q <= sec_now;
            adv_q  <= 1'b1;
          end
          OP_TIM: begin
            if (tim_now_evt) begin
              adv_q <= 1'b1;
            end else begin
              span_q <= cmd_arg;
              mode_q <= M_TIM;
            end
          end
          OP_CALL: begin
            if (ovf_evt) err_q <= 1'b1;
            else         adv_q <= 1'b1;
          end
          OP_RET: begin
            if (unf_evt) begin
              err_q <= 1'b1;
            end else begin
              raddr_q <= stk_top[ENT_W-1:TICK_W];
              dref_q  <= stk_top[TICK_W-1:0];
              rv_q    <= 1'b1;
              adv_q   <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (hold_done) begin
        adv_q  <= 1'b1;
        mode_q <= M_IDLE;
        if (mode_q == M_DELAY) dref_q <= tick_now;
      end
    end
  end

  assign busy      = (mode_q != M_IDLE);
  assign adv       = adv_q;
  assign ret_valid = rv_q;
  assign ret_addr  = raddr_q;
  assign stk_err   = err_q;

  // R3: a pending hold is not left before its condition is met
  a_r3_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold_done) |=> busy);

  // R4: an advance is only signalled with the controller idle
  a_r4_adv_idle: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !busy);

  // R6: a late delay never suspends
  a_r6_late_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    late_evt |=> (adv && !busy));

  // R8: a timed hold already due never suspends
  a_r8_tim_due: assert property (@(posedge clk) disable iff (!rst_n)
    tim_now_evt |=> (adv && !busy));

  // R10: a popped return always advances
  a_r10_ret_adv: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> adv);

  // R11 and R12: a stack error never advances
  a_r11_err_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |-> (!adv && !ret_valid));
endmodule

// File: tb/seqtc_ctl_bench.sv
`timescale 1ns/1ps
module seqtc_ctl_bench;
  localparam int TC    = 4;
  localparam int TPS   = 5;
  localparam int TW    = 8;
  localparam int SW    = 8;
  localparam int AW    = 12;
  localparam int DEP   = 10;
  localparam int TMASK = (1 << TW) - 1;
  localparam int SMASK = (1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [31:0]   cmd_arg = '0;
  logic [AW-1:0] cmd_ret_addr = '0;
  logic          busy, adv, ret_valid, stk_err;
  logic [AW-1:0] ret_addr;
  logic [TW-1:0] tick_now;
  logic [SW-1:0] sec_now;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  seqtc_ctl #(
    .TICK_CYCLES(TC), .TICKS_PER_SEC(TPS), .TICK_W(TW), .SEC_W(SW),
    .ADDR_W(AW), .STACK_DEPTH(DEP)
  ) u_seqtc_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_ret_addr(cmd_ret_addr), .busy(busy), .adv(adv),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .stk_err(stk_err),
    .tick_now(tick_now), .sec_now(sec_now)
  );

  // Behavioural reference model
  int m_pre, m_sub, m_tick, m_sec;
  int m_mode, m_start, m_n, m_dref, m_rsec;
  bit m_adv, m_rv, m_err;
  int m_raddr;
  int q_addr[$];
  int q_dref[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_sub = 0; m_tick = 0; m_sec = 0;
      m_mode = 0; m_start = 0; m_n = 0; m_dref = 0; m_rsec = 0;
      m_adv = 0; m_rv = 0; m_err = 0; m_raddr = 0;
      q_addr.delete(); q_dref.delete();
    end else begin
      int n_t, n_s;
      n_t = int'(cmd_arg) & TMASK;
      n_s = int'(cmd_arg) & SMASK;
      m_adv = 0; m_rv = 0; m_err = 0;
      if (m_mode == 0) begin
        if (cmd_valid) begin
          case (cmd_op)
            3'd1: begin
              m_start = m_tick; m_n = (n_t < 2) ? 1 : n_t; m_mode = 1;
            end
            3'd2: begin
              if (((m_tick - m_dref) & TMASK) >= n_t) begin
                m_adv = 1; m_dref = m_tick;
              end else begin
                m_n = n_t; m_mode = 2;
              end
            end
            3'd3: begin m_rsec = m_sec; m_adv = 1; end
            3'd4: begin
              if (((m_sec - m_rsec) & SMASK) >= n_s) m_adv = 1;
              else begin m_n = n_s; m_mode = 3; end
            end
            3'd5: begin
              if (q_addr.size() == DEP) m_err = 1;
              else begin
                q_addr.push_back(int'(cmd_ret_addr));
                q_dref.push_back(m_dref);
                m_adv = 1;
              end
            end
            3'd6: begin
              if (q_addr.size() == 0) m_err = 1;
              else begin
                m_raddr = q_addr.pop_back();
                m_dref  = q_dref.pop_back();
                m_rv = 1; m_adv = 1;
              end
            end
            default: ;
          endcase
        end
      end else if (m_mode == 1) begin
        if (((m_tick - m_start) & TMASK) >= m_n) begin m_adv = 1; m_mode = 0; end
      end else if (m_mode == 2) begin
        if (((m_tick - m_dref) & TMASK) >= m_n) begin
          m_adv = 1; m_mode = 0; m_dref = m_tick;
        end
      end else begin
        if (((m_sec - m_rsec) & SMASK) >= m_n) begin m_adv = 1; m_mode = 0; end
      end
      if (m_pre == TC - 1) begin
        m_pre = 0;
        m_tick = (m_tick + 1) & TMASK;
        if (m_sub == TPS - 1) begin
          m_sub = 0;
          m_sec = (m_sec + 1) & SMASK;
        end else m_sub++;
      end else m_pre++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(tick_now) == m_tick, "R1", "tick_now", tick_now, m_tick);
      chk(int'(sec_now) == m_sec, "R2", "sec_now", sec_now, m_sec);
      chk(busy == (m_mode != 0), cur_tag, "busy", busy, m_mode != 0);
      chk(adv == m_adv, cur_tag, "adv", adv, m_adv);
      chk(ret_valid == m_rv, cur_tag, "ret_valid", ret_valid, m_rv);
      chk(stk_err == m_err, cur_tag, "stk_err", stk_err, m_err);
      if (m_rv) chk(int'(ret_addr) == m_raddr, cur_tag, "ret_addr", ret_addr, m_raddr);
    end
  end

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 60000);
      summary();
    end
  end

  task automatic issue(input int op, input int arg, input int addr, input string tag);
    cur_tag = tag;
    cmd_op = 3'(op);
    cmd_arg = 32'(arg);
    cmd_ret_addr = AW'(addr);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_mode != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tick_now == '0, "R1", "reset tick_now", tick_now, 0);
    chk(sec_now == '0, "R2", "reset sec_now", sec_now, 0);
    chk(!busy && !adv && !stk_err && !ret_valid, "R3", "reset flags",
        {busy, adv, stk_err, ret_valid}, 0);
    rst_n = 1'b1;
    idle_cycles(3);

    // R4 waits of 0, 1, 3 and a masked 256 (low byte 0)
    issue(1, 0, 0, "R4");   wait_idle();
    issue(1, 1, 0, "R4");   wait_idle();
    issue(1, 3, 0, "R4");   wait_idle();
    idle_cycles(2);
    issue(1, 256, 0, "R4"); wait_idle();

    // R6 first delay after reset is late; R5 then a pending delay
    issue(2, 2, 0, "R6");   wait_idle();
    issue(2, 6, 0, "R5");   wait_idle();
    issue(2, 3, 0, "R5");   wait_idle();
    idle_cycles(30);
    issue(2, 2, 0, "R6");   wait_idle();
    issue(2, 0, 0, "R6");   wait_idle();

    // R3 commands while busy are ignored, unused codes do nothing
    issue(1, 5, 0, "R3");
    issue(3, 0, 0, "R3");
    issue(5, 0, 12'h0AA, "R3");
    wait_idle();
    issue(0, 9, 0, "R3");
    issue(7, 9, 0, "R3");
    issue(4, 0, 0, "R3");   wait_idle();
    issue(6, 0, 0, "R3");   wait_idle();

    // R7 and R8
    issue(3, 0, 0, "R7");   wait_idle();
    issue(4, 2, 0, "R8");   wait_idle();
    issue(4, 1, 0, "R8");   wait_idle();
    issue(4, 0, 0, "R8");   wait_idle();

    // R9 and R10 delay point saved and restored around a call
    issue(2, 0, 0, "R9");   wait_idle();
    issue(5, 0, 12'h123, "R9");
    idle_cycles(7);
    issue(2, 1, 0, "R10");  wait_idle();
    issue(6, 0, 0, "R10");
    issue(2, 4, 0, "R10");  wait_idle();

    // R11 fill the stack then overflow
    for (int i = 0; i < DEP; i++) issue(5, 0, 16 + i * 7, "R9");
    issue(5, 0, 12'hFFF, "R11");
    issue(5, 0, 12'hEEE, "R11");
    idle_cycles(1);
    // R10 pop in reverse order, R12 then underflow
    for (int i = 0; i < DEP; i++) issue(6, 0, 0, "R10");
    issue(6, 0, 0, "R12");
    issue(2, 0, 0, "R12");  wait_idle();

    // R13 delay across the tick wrap
    while (tick_now != TW'(250)) @(negedge clk);
    issue(2, 0, 0, "R13");  wait_idle();
    issue(2, 12, 0, "R13"); wait_idle();

    // R13 timed hold across the second wrap
    while (sec_now != SW'(254)) @(negedge clk);
    issue(3, 0, 0, "R13");  wait_idle();
    issue(4, 4, 0, "R13");  wait_idle();
    idle_cycles(20);

    summary();
  end
endmodule